// File: doc/BRIEF.md
# Triple Bit-Serial Adder with Sum Complement

This block holds three bit-serial adders that run side by side from one clock. Each lane takes one bit of each of two operands per clock, least significant bit first with the sign bit last, and presents one sum bit per clock. The sum bit is formed combinationally from the two present operand bits and a carry that the lane keeps from the previous bit position. The carry register takes its new value on the rising clock edge, so operand bits should change shortly after that edge and the sum settles within the bit period.

Each lane has its own invert control that complements the sum bit at its output without touching the carry path. One carry-clear input acts on all lanes together. It is raised during the last bit of a word, which is the bit period just before the next word's first bit, so words can follow one another with no idle bit. The stored carry of each lane is brought out for test observation only.

The operand streams carry one bit per clock with no valid or ready signalling. There is no back-pressure: the source presents a new bit every clock, and the sink samples the sum before the next rising edge. An asynchronous active-low reset clears all carries at power-on.

Top module: `serial_adder_trio`

## Requirements
- R1: The block has LANES independent lanes (default 3) that share `clk`, `rst_n` and `carry_clr`. Bit i of every per-lane vector belongs to lane i, and no lane's data affects another lane's sum or carry.
- R2: With `inv_in[i]` = 0, `sum_out[i]` equals `a_in[i]` XOR `b_in[i]` XOR the lane's stored carry, with no clock between input and output.
- R3: With `inv_in[i]` = 1, `sum_out[i]` is the complement of the R2 value. The invert input has no effect on the carry that is stored.
- R4: At each rising edge with `carry_clr` = 0, a lane's stored carry becomes the majority of `a_in[i]`, `b_in[i]` and the previous stored carry.
- R5: At a rising edge with `carry_clr` = 1, every lane's stored carry becomes 0, whatever the data. During that bit period the sum still uses the carry stored before the edge.
- R6: While `rst_n` = 0, all stored carries are 0 at once, without waiting for a clock edge.
- R7: Words of any length from 4 to 16 bits, sent LSB first and back to back with `carry_clr` raised on each word's last bit, yield on `sum_out` the two's-complement sum of the operands modulo 2^length (bitwise complemented if `inv_in` is held at 1 for the word).
- R8: `carry_out[i]` shows lane i's stored carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; carries update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all carries |
| carry_clr | input | 1 | Synchronous carry clear for all lanes, raised on a word's last bit |
| a_in | input | LANES | First operand bit per lane |
| b_in | input | LANES | Second operand bit per lane |
| inv_in | input | LANES | Per-lane sum complement control |
| sum_out | output | LANES | Serial sum bit per lane |
| carry_out | output | LANES | Stored carry per lane, for test observation |

## Verification
The bench streams random words of 4 to 16 bits back to back on all lanes with the clear raised on every last bit. A clear that lands one bit late or early, or that loses to the carry update, corrupts the low bits of the following word. Directed steps set a carry to 1 and then raise the invert control, so a design that feeds the inverted sum into the carry logic shows the wrong carry on the next bit. Further steps assert the clear with both operands at 1, where an update that wins over the clear leaves a carry of 1. A step that drops reset between clock edges catches a reset that waits for the clock.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  localparam int unsigned SADD_LANES_DEFAULT = 3;

  // Majority of three bits: the carry rule of a full adder.
  function automatic logic sadd_majority(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/sadd_full_add.sv
module sadd_full_add
  import sadd_pkg::*;
(
  input  logic op_x,
  input  logic op_y,
  input  logic cin,
  output logic sum_raw,
  output logic cout
);

  always_comb begin
    sum_raw = op_x ^ op_y ^ cin;
    cout    = sadd_majority(op_x, op_y, cin);
  end

endmodule

// File: rtl/sadd_carry_reg.sv
module sadd_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic carry_d,
  output logic carry_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (clr) carry_q <= 1'b0;
    else          carry_q <= carry_d;
  end

  // Clear wins over any incoming carry.
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (carry_q == 1'b0));

  // Stored carry is zero whenever reset is held.
  assert_reset_zero_R6: assert property (@(posedge clk)
    !rst_n |-> (carry_q == 1'b0));

endmodule

// File: rtl/sadd_lane.sv
module sadd_lane
  import sadd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carry_clr,
  input  logic a_i,
  input  logic b_i,
  input  logic inv_i,
  output logic sum_o,
  output logic carry_o
);

  logic carry_q;
  logic carry_next;
  logic sum_plain;

  sadd_full_add u_fa (
    .op_x    (a_i),
    .op_y    (b_i),
    .cin     (carry_q),
    .sum_raw (sum_plain),
    .cout    (carry_next)
  );

  sadd_carry_reg u_creg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (carry_clr),
    .carry_d (carry_next),
    .carry_q (carry_q)
  );

  // Invert acts on the output only; carry_next is taken before it.
  assign sum_o   = sum_plain ^ inv_i;
  assign carry_o = carry_q;

  // Output relation across the adder cell and the invert stage (R2, R3).
  assert_sum_relation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_o ^ inv_i) == (a_i ^ b_i ^ carry_q)));

  // Carry follows majority regardless of the invert control (R4, R3).
  assert_carry_majority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_clr |=> (carry_q == sadd_majority($past(a_i), $past(b_i), $past(carry_q))));

endmodule

// File: rtl/serial_adder_trio.sv
module serial_adder_trio
  import sadd_pkg::*;
#(
  parameter int unsigned LANES = SADD_LANES_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carry_clr,
  input  logic [LANES-1:0] a_in,
  input  logic [LANES-1:0] b_in,
  input  logic [LANES-1:0] inv_in,
  output logic [LANES-1:0] sum_out,
  output logic [LANES-1:0] carry_out
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sadd_lane u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .carry_clr (carry_clr),
        .a_i       (a_in[g]),
        .b_i       (b_in[g]),
        .inv_i     (inv_in[g]),
        .sum_o     (sum_out[g]),
        .carry_o   (carry_out[g])
      );
    end
  endgenerate

  // Shared clear reaches every lane at the same edge (R1).
  assert_all_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> (carry_out == '0));

endmodule

// File: tb/tb_serial_adder_trio.sv
module tb_serial_adder_trio;
  localparam int L = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, carry_clr;
  logic [L-1:0] a_in, b_in, inv_in;
  logic [L-1:0] sum_out, carry_out;

  serial_adder_trio #(.LANES(L)) dut (
    .clk(clk), .rst_n(rst_n), .carry_clr(carry_clr),
    .a_in(a_in), .b_in(b_in), .inv_in(inv_in),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  int checks = 0;
  int fails  = 0;
  bit stream_on = 1'b0;
  bit finished  = 1'b0;

  typedef struct {
    int        len;
    logic [15:0] exp;
    bit        inv;
  } item_t;

  item_t       exp_q [L][$];
  int          bit_idx [L];
  logic [15:0] acc [L];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: reassembles serial sums and compares with the scoreboard queue.
  initial begin
    for (int l = 0; l < L; l++) begin bit_idx[l] = 0; acc[l] = '0; end
  end

  always @(negedge clk) begin
    if (stream_on) begin
      for (int l = 0; l < L; l++) begin
        if (exp_q[l].size() > 0) begin
          acc[l][bit_idx[l]] = sum_out[l];
          bit_idx[l]++;
          if (bit_idx[l] == exp_q[l][0].len) begin
            if (exp_q[l][0].inv)
              check($sformatf("R3 R7 lane%0d len%0d inverted word", l, exp_q[l][0].len),
                    {16'h0, acc[l]}, {16'h0, exp_q[l][0].exp});
            else
              check($sformatf("R7 lane%0d len%0d word", l, exp_q[l][0].len),
                    {16'h0, acc[l]}, {16'h0, exp_q[l][0].exp});
            void'(exp_q[l].pop_front());
            bit_idx[l] = 0;
            acc[l] = '0;
          end
        end
      end
    end
  end

  // Driver: picks words, pushes expected sums, then streams bits LSB first.
  task automatic send_words(input int n);
    for (int w = 0; w < n; w++) begin
      int          len;
      logic [15:0] mask;
      logic [15:0] wa [L];
      logic [15:0] wb [L];
      logic [L-1:0] winv;
      item_t       it;
      len  = 4 + int'($urandom % 13);
      mask = 16'((32'd1 << len) - 1);
      for (int l = 0; l < L; l++) begin
        wa[l]   = 16'($urandom) & mask;
        wb[l]   = 16'($urandom) & mask;
        winv[l] = 1'($urandom);
        it.len  = len;
        it.inv  = winv[l];
        it.exp  = (wa[l] + wb[l]) & mask;
        if (winv[l]) it.exp = ~it.exp & mask;
        exp_q[l].push_back(it);
      end
      for (int i = 0; i < len; i++) begin
        @(posedge clk); #1;
        for (int l = 0; l < L; l++) begin
          a_in[l]   = wa[l][i];
          b_in[l]   = wb[l][i];
          inv_in[l] = winv[l];
        end
        carry_clr = (i == len - 1);
        stream_on = 1'b1;
      end
    end
    @(negedge clk); #1;
    stream_on = 1'b0;
  endtask

  task automatic step(input logic [L-1:0] a, input logic [L-1:0] b,
                      input logic [L-1:0] inv, input logic clr);
    @(posedge clk); #1;
    a_in = a; b_in = b; inv_in = inv; carry_clr = clr;
  endtask

  initial begin
    rst_n = 1'b0; carry_clr = 1'b0;
    a_in = '0; b_in = '0; inv_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 carry under reset", {29'h0, carry_out}, 32'h0);
    check("R2 sum zero inputs", {29'h0, sum_out}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;

    // Lane-distinct patterns, carries all 0.
    step(3'b001, 3'b011, 3'b000, 1'b0);
    @(negedge clk);
    check("R2 R1 sum per lane", {29'h0, sum_out}, 32'h2);
    step(3'b101, 3'b110, 3'b011, 1'b0);
    check("R4 R8 R1 carry after majority", {29'h0, carry_out}, 32'h1);
    // lane0 carry 1, a=1 b=0 inv=1; lane1 a=0 b=1 inv=1; lane2 a=1 b=1
    @(negedge clk);
    check("R3 inverted sums", {29'h0, sum_out}, 32'h1);
    step(3'b111, 3'b111, 3'b000, 1'b1);
    check("R3 R4 carry unaffected by invert", {29'h0, carry_out}, 32'h5);
    @(negedge clk);
    check("R5 sum uses stored carry during clear", {29'h0, sum_out}, 32'h5);
    step(3'b111, 3'b111, 3'b000, 1'b0);
    check("R5 R1 clear beats update on all lanes", {29'h0, carry_out}, 32'h0);
    step(3'b000, 3'b000, 3'b000, 1'b0);
    check("R4 R8 carries set", {29'h0, carry_out}, 32'h7);
    @(negedge clk);
    check("R2 sum from carry only", {29'h0, sum_out}, 32'h7);
    rst_n = 1'b0; #1;
    check("R6 asynchronous reset", {29'h0, carry_out}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    check("R6 carry stays clear after release", {29'h0, carry_out}, 32'h0);

    send_words(45);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule